// File: doc/BRIEF.md
# DAC Output Load-Presence Sequencer

This controller performs one load-presence check on one of six DAC output channels. A single-cycle start request carries a 3-bit channel index. The sequencer puts the index on a select bus and waits for a minimum select-settling time. It then drives an active-low evaluation strobe to an external threshold comparator and holds it low for a minimum width. In the last low cycle it samples the comparator. It then releases the strobe and reports the result with a one-cycle done pulse.

All minimum intervals are given as parameters in nanoseconds, together with the clock frequency in MHz. Each interval becomes a cycle count of ceil(ns * MHz / 1000), with a floor of one cycle, so that every minimum time is met.

A low comparator output means the selected output sits above the threshold, which means no load is attached. A high output means a load is present. Channel indices 6 and 7 are refused: the sequencer raises an error flag and does not issue a strobe.

States:
- IDLE: strobe high and not busy.
- SETUP: select bus driven, strobe high. Lasts SETUP_CYC cycles.
- STROBE: strobe low. Lasts LOW_CYC cycles.
- DONE: strobe high and done pulsed.
- REJECT: error flag set and done pulsed, with no strobe.

Transitions:
- IDLE to SETUP: start with a valid index.
- IDLE to REJECT: start with index 6 or 7.
- SETUP to STROBE: setup timer expired.
- STROBE to DONE: low-width timer expired. The result is captured on this edge.
- DONE to IDLE and REJECT to IDLE: unconditional.

Top module: `lp_detect_seq`

## Requirements
- R1: When a start is accepted with an index of 0 to 5, that index appears on `sel_o` before the strobe falls and stays there for the whole check.
- R2: After reset the strobe is high, busy and done are low, and the select bus reads 0. The strobe is high in every cycle in which busy is low.
- R3: The select bus is driven and stable, with the strobe high, for SETUP_CYC cycles (5 at defaults: 100 ns at 50 MHz) before the strobe falls. It does not change while the strobe is low.
- R4: The strobe stays low for exactly LOW_CYC cycles. LOW_CYC is the larger of the ceil-converted strobe width (200 ns) and result-settle time (100 ns), which gives 10 cycles at defaults.
- R5: The comparator is sampled only in the last low cycle. A high value there sets `load_found_o` to 1 and a low value sets it to 0. Comparator values in every other cycle have no effect.
- R6: `busy_o` is high from the cycle after the accepted start up to and including the done cycle, and low in the cycle after it. `done_o` is a single-cycle pulse, asserted in the first cycle in which the strobe is high again.
- R7: A start with index 6 or 7 gives `done_o` with `chan_err_o` = 1 in the next cycle. In that case the strobe never falls and `load_found_o` is 0.
- R8: A start request that arrives while busy is ignored. It produces no extra done and does not change the select bus.
- R9: `load_found_o` and `chan_err_o` hold their values until the next accepted start, which clears both.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start request, one cycle |
| chan_i | input | CH_W | Channel index sampled with start |
| cmp_i | input | 1 | Comparator output, high = load present |
| sel_o | output | CH_W | Channel-select bus to the analog side |
| strobe_n_o | output | 1 | Active-low evaluation strobe |
| busy_o | output | 1 | Check in progress |
| done_o | output | 1 | One-cycle completion pulse |
| load_found_o | output | 1 | Held result: load attached |
| chan_err_o | output | 1 | Held flag: invalid channel requested |

## Verification
A state register that is stuck or skips a state shows up at the ports within one check. It appears as a wrong count of strobe-high setup cycles before the falling edge, a wrong strobe-low width, or a done pulse that is missing, doubled or early. A result captured in the wrong cycle shows up as an inverted `load_found_o` on the next done, because the bench comparator model shows the true level only in the final low cycle. A busy-state guard that fails shows up as a select-bus change or an extra done pulse during a check.

// File: rtl/lp_pkg.sv
package lp_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_STROBE,
        ST_DONE,
        ST_REJECT
    } lp_state_e;

    // Round a nanosecond interval up to whole clock cycles, never below one.
    function automatic int ns_to_cycles(input int ns, input int mhz);
        int c;
        c = (ns * mhz + 999) / 1000;
        return (c < 1) ? 1 : c;
    endfunction

    function automatic int max_int(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/lp_timer.sv
module lp_timer #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         zero
);
    logic [W-1:0] count;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              count <= '0;
        else if (load)           count <= load_val;
        else if (count != '0)    count <= count - 1'b1;
    end

    assign zero = (count == '0);

    // The counter never rises except through a load.
    p_no_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> (count <= $past(count)));
endmodule

// File: rtl/lp_capture.sv
module lp_capture (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic cap,
    input  logic d,
    output logic q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   q <= 1'b0;
        else if (clr) q <= 1'b0;
        else if (cap) q <= d;
    end
endmodule

// File: rtl/lp_detect_seq.sv
module lp_detect_seq
    import lp_pkg::*;
#(
    parameter int CLK_MHZ       = 50,
    parameter int SEL_SETUP_NS  = 100,
    parameter int STROBE_MIN_NS = 200,
    parameter int EVAL_WAIT_NS  = 100,
    parameter int NUM_CH        = 6,
    parameter int CH_W          = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start_i,
    input  logic [CH_W-1:0] chan_i,
    input  logic            cmp_i,
    output logic [CH_W-1:0] sel_o,
    output logic            strobe_n_o,
    output logic            busy_o,
    output logic            done_o,
    output logic            load_found_o,
    output logic            chan_err_o
);
    localparam int SETUP_CYC = ns_to_cycles(SEL_SETUP_NS, CLK_MHZ);
    localparam int LOW_CYC   = max_int(ns_to_cycles(STROBE_MIN_NS, CLK_MHZ),
                                       ns_to_cycles(EVAL_WAIT_NS, CLK_MHZ));
    localparam int CNT_W     = $clog2(max_int(SETUP_CYC, LOW_CYC) + 1);
    localparam int RUN_W     = CNT_W + 1;
    localparam logic [CH_W:0] NUM_CH_L = (CH_W+1)'(NUM_CH);

    lp_state_e       state, state_nx;
    logic            tmr_load, tmr_zero;
    logic [CNT_W-1:0] tmr_val;
    logic            chan_ok, accept, capture;
    logic [CH_W-1:0] sel_q;
    logic            err_q;

    assign chan_ok = ({1'b0, chan_i} < NUM_CH_L);
    assign accept  = (state == ST_IDLE) && start_i;
    assign capture = (state == ST_STROBE) && tmr_zero;

    lp_timer #(.W(CNT_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .zero     (tmr_zero)
    );

    lp_capture u_result (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (accept),
        .cap   (capture),
        .d     (cmp_i),
        .q     (load_found_o)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // Channel and error holding registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sel_q <= '0;
            err_q <= 1'b0;
        end else if (accept) begin
            err_q <= !chan_ok;
            if (chan_ok) sel_q <= chan_i;
        end
    end

    // Next state and timer control
    always_comb begin
        state_nx = state;
        tmr_load = 1'b0;
        tmr_val  = '0;
        unique case (state)
            ST_IDLE: begin
                if (start_i) begin
                    if (chan_ok) begin
                        state_nx = ST_SETUP;
                        tmr_load = 1'b1;
                        tmr_val  = CNT_W'(SETUP_CYC - 1);
                    end else begin
                        state_nx = ST_REJECT;
                    end
                end
            end
            ST_SETUP: begin
                if (tmr_zero) begin
                    state_nx = ST_STROBE;
                    tmr_load = 1'b1;
                    tmr_val  = CNT_W'(LOW_CYC - 1);
                end
            end
            ST_STROBE: begin
                if (tmr_zero) state_nx = ST_DONE;
            end
            ST_DONE:   state_nx = ST_IDLE;
            ST_REJECT: state_nx = ST_IDLE;
            default:   state_nx = ST_IDLE;
        endcase
    end

    // Outputs decoded from the state
    always_comb begin
        strobe_n_o = 1'b1;
        busy_o     = 1'b1;
        done_o     = 1'b0;
        unique case (state)
            ST_IDLE:   busy_o     = 1'b0;
            ST_SETUP:  ;
            ST_STROBE: strobe_n_o = 1'b0;
            ST_DONE:   done_o     = 1'b1;
            ST_REJECT: done_o     = 1'b1;
            default:   busy_o     = 1'b0;
        endcase
    end

    assign sel_o      = sel_q;
    assign chan_err_o = err_q;

    // ---------------- assertions ----------------
    logic [RUN_W-1:0] a_low_run, a_setup_run;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            a_low_run   <= '0;
            a_setup_run <= '0;
        end else begin
            a_low_run   <= !strobe_n_o ? a_low_run + 1'b1 : '0;
            a_setup_run <= !busy_o ? '0 :
                           (strobe_n_o && !done_o) ? a_setup_run + 1'b1 : a_setup_run;
        end
    end

    p_idle_strobe_high_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> strobe_n_o);

    p_sel_valid_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !strobe_n_o |-> ({1'b0, sel_o} < NUM_CH_L));

    p_sel_stable_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!strobe_n_o && !$fell(strobe_n_o)) |-> $stable(sel_o));

    p_setup_time_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(strobe_n_o) |-> (a_setup_run >= RUN_W'(SETUP_CYC)));

    p_low_width_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(strobe_n_o) |-> (a_low_run == RUN_W'(LOW_CYC)));

    p_done_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    p_done_ends_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !busy_o);

    p_reject_no_strobe_r7: assert property (@(posedge clk) disable iff (!rst_n)
        chan_err_o |-> strobe_n_o);

    p_result_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && !start_i) |=> $stable(load_found_o) && $stable(chan_err_o));
endmodule

// File: tb/tb_lp_detect_seq.sv
module tb_lp_detect_seq;
    localparam int SETUP_EXP = 5;
    localparam int LOW_EXP   = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_i = 1'b0;
    logic [2:0] chan_i = '0;
    logic       cmp_i = 1'b0;
    logic [2:0] sel_o;
    logic       strobe_n_o, busy_o, done_o, load_found_o, chan_err_o;

    always #10 clk = ~clk;

    lp_detect_seq dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .chan_i(chan_i),
        .cmp_i(cmp_i), .sel_o(sel_o), .strobe_n_o(strobe_n_o),
        .busy_o(busy_o), .done_o(done_o), .load_found_o(load_found_o),
        .chan_err_o(chan_err_o)
    );

    typedef struct { int chan; bit load; bit err; } exp_t;
    exp_t sb[$];

    int checks = 0;
    int fails  = 0;
    bit cmp_level = 1'b0;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // Monitor and comparator model
    bit prev_strobe = 1'b1, done_prev = 1'b0, fell_seen = 1'b0;
    int low_cnt = 0, setup_cnt = 0;
    logic [2:0] low_sel = '0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (!strobe_n_o) begin
                if (prev_strobe) begin
                    check(setup_cnt == SETUP_EXP, "R3 setup cycles", setup_cnt, SETUP_EXP);
                    if (sb.size() > 0)
                        check(int'(sel_o) == sb[0].chan, "R1 sel at strobe", sel_o, sb[0].chan);
                    fell_seen = 1'b1;
                    low_sel   = sel_o;
                end else begin
                    check(sel_o == low_sel, "R3 sel stable", sel_o, low_sel);
                end
                low_cnt++;
            end else begin
                if (!prev_strobe)
                    check(low_cnt == LOW_EXP, "R4 strobe width", low_cnt, LOW_EXP);
                if (busy_o && !done_o) setup_cnt++;
            end
            if (!busy_o)
                check(strobe_n_o == 1'b1, "R2 strobe idle", strobe_n_o, 1);
            if (done_o) begin
                check(!done_prev, "R6 done single", done_prev, 0);
                check(busy_o == 1'b1, "R6 busy at done", busy_o, 1);
                if (sb.size() == 0) begin
                    check(1'b0, "R8 unexpected done", 1, 0);
                end else begin
                    exp_t e;
                    e = sb.pop_front();
                    check(load_found_o == e.load, "R5 load result", load_found_o, e.load);
                    check(chan_err_o == e.err, "R7 error flag", chan_err_o, e.err);
                    if (e.err) check(!fell_seen, "R7 no strobe", fell_seen, 0);
                end
                low_cnt = 0; setup_cnt = 0; fell_seen = 1'b0;
            end
            prev_strobe = strobe_n_o;
            done_prev   = done_o;
            // True level only in the last low cycle; inverted otherwise.
            cmp_i = (!strobe_n_o && low_cnt == LOW_EXP) ? cmp_level : ~cmp_level;
        end
    end

    task automatic run_check(input int chan, input bit lvl, input bit poke);
        while (busy_o) @(negedge clk);
        cmp_level = lvl;
        chan_i    = 3'(chan);
        start_i   = 1'b1;
        sb.push_back('{chan, (chan < 6) ? lvl : 1'b0, chan >= 6});
        @(negedge clk);
        start_i = 1'b0;
        if (poke) begin
            repeat (3) @(negedge clk);
            chan_i  = 3'((chan + 1) % 6);
            start_i = 1'b1;      // R8: must be ignored
            @(negedge clk);
            start_i = 1'b0;
        end
        while (!done_o) @(negedge clk);
        @(negedge clk);
        check(!busy_o, "R6 busy after done", busy_o, 0);
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        check(1'b0, "watchdog", 0, 1);
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        check(strobe_n_o == 1'b1, "R2 reset strobe", strobe_n_o, 1);
        check(busy_o == 1'b0, "R2 reset busy", busy_o, 0);
        check(done_o == 1'b0, "R2 reset done", done_o, 0);
        check(sel_o == 3'd0, "R2 reset sel", sel_o, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        run_check(0, 1'b1, 1'b0);
        run_check(3, 1'b0, 1'b0);
        run_check(5, 1'b1, 1'b1);

        // R9 hold and R8 no stray done
        repeat (20) @(negedge clk);
        check(load_found_o == 1'b1, "R9 result held", load_found_o, 1);
        check(!done_o && !busy_o, "R8 no stray activity", busy_o, 0);

        // R9 cleared on next accepted start
        chan_i = 3'd2; cmp_level = 1'b0; start_i = 1'b1;
        sb.push_back('{2, 1'b0, 1'b0});
        @(negedge clk);
        start_i = 1'b0;
        check(load_found_o == 1'b0, "R9 result cleared", load_found_o, 0);
        while (!done_o) @(negedge clk);
        @(negedge clk);

        run_check(6, 1'b1, 1'b0);
        check(chan_err_o == 1'b1, "R7 error held", chan_err_o, 1);
        run_check(7, 1'b0, 1'b0);
        run_check(1, 1'b1, 1'b0);
        check(chan_err_o == 1'b0, "R9 error cleared", chan_err_o, 0);
        run_check(4, 1'b0, 1'b1);

        repeat (5) @(negedge clk);
        check(sb.size() == 0, "R6 all done seen", sb.size(), 0);
        finish_run();
    end
endmodule